// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps one write-back cache coherent with its peers on a shared snooping bus. It holds a coherence state and a tag for each line of a small direct-mapped array. The states are Modified (the only copy, newer than memory), Exclusive (the only copy, equal to memory), Shared (other caches may hold it, equal to memory) and Invalid. It serves load and store requests from its processor. When a request cannot be completed locally, it requests the bus and places a coherence command on it. It also watches every command that other caches place on the bus and updates or gives up its own copies.

The bus is single-owner, and a separate arbiter grants it. All caches see the granted command in the same cycle. A wired-OR shared line runs back to the requester in that same cycle. A cache that sees a read of a line it holds raises the shared line. The reader then loads the line as Exclusive when no one answered and as Shared otherwise. A later store to an Exclusive line therefore needs no bus traffic. A dirty copy hit by another cache's read or read-for-ownership is written back through a one-cycle intervention pulse.

The controller decides which command to place on the bus in the cycle the grant arrives, using the line state of that cycle. A line that was lost to another cache while the request waited for the bus is handled correctly.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `cpu_state_o`, and `bus_req_o` and `cpu_done_o` are low while no request is pending.
- R2: A load miss places a bus read (`bus_cmd_o`=0). The line is filled as Exclusive (state code 2) if `shared_i` is low in the grant cycle, and as Shared (code 1) if it is high. State codes are Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R3: A miss whose indexed line is Modified with another tag first places a write-back (`bus_cmd_o`=3) carrying the victim's address. It places the read or read-for-ownership only after that, and `cpu_done_o` is raised only with the second command.
- R4: A store to an Exclusive line becomes Modified with no bus command, and `cpu_done_o` is raised in the request cycle. Loads hitting Modified, Exclusive or Shared lines and stores hitting Modified lines also complete without bus activity.
- R5: A store hitting a Shared line places an invalidate (`bus_cmd_o`=2). A store miss places a read-for-ownership (`bus_cmd_o`=1). Both leave the line Modified.
- R6: A snooped read hitting an Exclusive or Shared line raises `shared_o` in that cycle and leaves the line Shared, with no write-back pulse.
- R7: A snooped read hitting a Modified line raises `snp_wb_o` and `shared_o` in that cycle and leaves the line Shared.
- R8: A snooped read-for-ownership hitting a Modified line raises `snp_wb_o` and invalidates the line. A snooped read-for-ownership or invalidate hitting a Shared or Exclusive line invalidates it without a write-back pulse.
- R9: The controller does not react to its own bus command. Snooped commands whose tag differs from the stored tag leave the line unchanged.
- R10: A store that waits for the bus to upgrade a Shared line, and loses that line to another cache's command before its grant, places a read-for-ownership instead of an invalidate.
- R11: A request that could complete locally is held back for any cycle in which a snooped command targets the same index. It is re-evaluated against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid_i | input | 1 | Processor request pending, held until done |
| cpu_write_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Request address (low INDEX_W bits index the line) |
| cpu_done_o | output | 1 | Request completes in this cycle |
| cpu_state_o | output | 2 | State of the line for `cpu_addr_i` (Invalid on tag mismatch) |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant for this cycle |
| bus_valid_o | output | 1 | This cache drives a command this cycle |
| bus_cmd_o | output | 2 | Command: 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr_o | output | ADDR_W | Command address |
| snp_valid_i | input | 1 | A command is on the bus |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped address |
| shared_i | input | 1 | OR of the other caches' shared answers |
| shared_o | output | 1 | This cache holds the snooped read's line |
| snp_wb_o | output | 1 | Intervention write-back of a dirty snooped line |

## Verification
The bench builds two controllers with 6-bit addresses and four lines. That leaves a 4-bit tag, so addresses such as 0x05 and 0x15 fall on the same index. Evictions, dirty write-backs and same-index/different-tag snoops then come up within a few requests. A selectable arbiter priority lets both caches request at once. With it the bench forces a lost upgrade and a snoop colliding with a local store hit.

// File: rtl/mesi_pkg.sv
// Shared encodings for the coherence controller.
// Assumes: two-bit state and command fields on every port.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_RDX = 2'd1,
        OP_INV = 2'd2,
        OP_WB  = 2'd3
    } bus_op_t;
endpackage

// File: rtl/mesi_line_array.sv
// State and tag storage for a direct-mapped array of lines.
// Two combinational read ports (processor side and snoop side) and two write
// ports. Assumes the two write ports never target the same index in one cycle;
// the snoop port wins if they ever do.
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] pa_idx,
    output line_st_t           pa_st,
    output logic [TAG_W-1:0]   pa_tag,
    input  logic [INDEX_W-1:0] pb_idx,
    output line_st_t           pb_st,
    output logic [TAG_W-1:0]   pb_tag,
    input  logic               wa_en,
    input  logic [INDEX_W-1:0] wa_idx,
    input  line_st_t           wa_st,
    input  logic [TAG_W-1:0]   wa_tag,
    input  logic               wb_en,
    input  logic [INDEX_W-1:0] wb_idx,
    input  line_st_t           wb_st
);
    localparam int LINES = 1 << INDEX_W;

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    // Read ports: plain lookups by index.
    assign pa_st  = st_q[pa_idx];
    assign pa_tag = tag_q[pa_idx];
    assign pb_st  = st_q[pb_idx];
    assign pb_tag = tag_q[pb_idx];

    // Line update: reset to Invalid, snoop write over processor write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end else if (wb_en && (wb_idx == INDEX_W'(i))) begin
                st_q[i] <= wb_st;
            end else if (wa_en && (wa_idx == INDEX_W'(i))) begin
                st_q[i]  <= wa_st;
                tag_q[i] <= wa_tag;
            end
        end
    end

    // R11
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_en && wb_en && (wa_idx == wb_idx)));
endmodule

// File: rtl/mesi_snoop_resp.sv
// Snoop response: decides the shared answer, the dirty intervention and the
// new line state for a command seen on the bus.
// Assumes the caller has already removed this cache's own commands.
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic     snp_act,
    input  bus_op_t  snp_op,
    input  logic     tag_eq,
    input  line_st_t line_st,
    output logic     shared_o,
    output logic     wb_o,
    output logic     upd_en,
    output line_st_t upd_st
);
    logic hit;
    assign hit = (line_st != ST_I) && tag_eq;

    // Response decode for one snooped command.
    always_comb begin
        shared_o = 1'b0;
        wb_o     = 1'b0;
        upd_en   = 1'b0;
        upd_st   = line_st;
        if (snp_act && hit) begin
            unique case (snp_op)
                OP_RD: begin
                    shared_o = 1'b1;
                    wb_o     = (line_st == ST_M);
                    upd_en   = (line_st != ST_S);
                    upd_st   = ST_S;
                end
                OP_RDX: begin
                    wb_o   = (line_st == ST_M);
                    upd_en = 1'b1;
                    upd_st = ST_I;
                end
                OP_INV: begin
                    upd_en = 1'b1;
                    upd_st = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_cpu_seq.sv
// Processor-side sequencer. Idle requests that hit with enough permission
// finish in the request cycle; others wait for the bus. The command is chosen
// in the grant cycle from the line state of that cycle, so a line lost while
// waiting is handled. Assumes the request is held stable until done.
module mesi_cpu_seq
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid_i,
    input  logic               cpu_write_i,
    input  logic [INDEX_W-1:0] req_idx,
    input  logic [TAG_W-1:0]   req_tag,
    input  line_st_t           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic               snp_block_i,
    input  logic               bus_gnt_i,
    input  logic               shared_i,
    output logic               cpu_done_o,
    output logic               bus_req_o,
    output logic               bus_valid_o,
    output bus_op_t            bus_op_o,
    output logic [INDEX_W+TAG_W-1:0] bus_addr_o,
    output logic               wr_en_o,
    output line_st_t           wr_st_o,
    output logic [TAG_W-1:0]   wr_tag_o
);
    typedef enum logic {SQ_IDLE, SQ_WAIT} seq_t;

    seq_t seq_q, seq_d;
    logic hit, dirty_victim, local_ok;

    assign hit          = (line_st != ST_I) && (line_tag == req_tag);
    assign dirty_victim = (line_st == ST_M) && (line_tag != req_tag);
    assign local_ok     = hit && (!cpu_write_i || line_st == ST_M || line_st == ST_E);

    // Next-step decode: local completion, bus command choice and line write.
    always_comb begin
        seq_d       = seq_q;
        cpu_done_o  = 1'b0;
        bus_req_o   = 1'b0;
        bus_valid_o = 1'b0;
        bus_op_o    = OP_RD;
        bus_addr_o  = {req_tag, req_idx};
        wr_en_o     = 1'b0;
        wr_st_o     = line_st;
        wr_tag_o    = line_tag;
        unique case (seq_q)
            SQ_IDLE: begin
                if (cpu_valid_i && !snp_block_i) begin
                    if (local_ok) begin
                        cpu_done_o = 1'b1;
                        if (cpu_write_i && line_st == ST_E) begin
                            wr_en_o = 1'b1;
                            wr_st_o = ST_M;
                        end
                    end else begin
                        seq_d = SQ_WAIT;
                    end
                end
            end
            SQ_WAIT: begin
                bus_req_o = 1'b1;
                if (dirty_victim) begin
                    bus_op_o   = OP_WB;
                    bus_addr_o = {line_tag, req_idx};
                end else if (!cpu_write_i) begin
                    bus_op_o = OP_RD;
                end else if (hit) begin
                    bus_op_o = OP_INV;
                end else begin
                    bus_op_o = OP_RDX;
                end
                if (bus_gnt_i) begin
                    bus_valid_o = 1'b1;
                    wr_en_o     = 1'b1;
                    if (bus_op_o == OP_WB) begin
                        wr_st_o = ST_I;
                    end else begin
                        wr_tag_o   = req_tag;
                        wr_st_o    = (bus_op_o == OP_RD) ? (shared_i ? ST_S : ST_E) : ST_M;
                        cpu_done_o = 1'b1;
                        seq_d      = SQ_IDLE;
                    end
                end
            end
            default: seq_d = SQ_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SQ_IDLE;
        else        seq_q <= seq_d;
    end

    // R3
    wb_not_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_op_o == OP_WB) |-> !cpu_done_o);
    // R4
    silent_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done_o && !bus_valid_o) |->
            (line_tag == req_tag && line_st != ST_I &&
             (!cpu_write_i || line_st != ST_S)));
    // R5
    inv_only_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_op_o == OP_INV) |-> (line_st == ST_S && line_tag == req_tag));
    // R1
    req_only_when_asked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> cpu_valid_i);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the per-cache coherence controller: line array, processor sequencer
// and snoop responder. Snooped commands are ignored while this cache holds the
// grant. Assumes a single-owner bus and a shared line ORed outside the block.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int INDEX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid_i,
    input  logic              cpu_write_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic              cpu_done_o,
    output logic [1:0]        cpu_state_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_valid_o,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              shared_i,
    output logic              shared_o,
    output logic              snp_wb_o
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx, wa_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag, a_tag, b_tag, wa_tag;
    line_st_t           a_st, b_st, wa_st, wb_st;
    logic               wa_en, wb_en, snp_act, snp_block, snp_hit;
    bus_op_t            snp_op, own_op;

    // Address split and snoop qualification.
    assign cpu_idx   = cpu_addr_i[INDEX_W-1:0];
    assign cpu_tag   = cpu_addr_i[ADDR_W-1:INDEX_W];
    assign snp_idx   = snp_addr_i[INDEX_W-1:0];
    assign snp_tag   = snp_addr_i[ADDR_W-1:INDEX_W];
    assign snp_op    = bus_op_t'(snp_cmd_i);
    assign snp_act   = snp_valid_i && !bus_gnt_i;
    assign snp_block = snp_act && (snp_idx == cpu_idx);
    assign snp_hit   = (b_st != ST_I) && (b_tag == snp_tag);

    // Processor-visible state of the requested address.
    assign cpu_state_o = (a_tag == cpu_tag) ? a_st : ST_I;
    assign bus_cmd_o   = own_op;

    mesi_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) lines_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pa_idx (cpu_idx),
        .pa_st  (a_st),
        .pa_tag (a_tag),
        .pb_idx (snp_idx),
        .pb_st  (b_st),
        .pb_tag (b_tag),
        .wa_en  (wa_en),
        .wa_idx (wa_idx),
        .wa_st  (wa_st),
        .wa_tag (wa_tag),
        .wb_en  (wb_en),
        .wb_idx (snp_idx),
        .wb_st  (wb_st)
    );

    assign wa_idx = cpu_idx;

    mesi_cpu_seq #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_valid_i (cpu_valid_i),
        .cpu_write_i (cpu_write_i),
        .req_idx     (cpu_idx),
        .req_tag     (cpu_tag),
        .line_st     (a_st),
        .line_tag    (a_tag),
        .snp_block_i (snp_block),
        .bus_gnt_i   (bus_gnt_i),
        .shared_i    (shared_i),
        .cpu_done_o  (cpu_done_o),
        .bus_req_o   (bus_req_o),
        .bus_valid_o (bus_valid_o),
        .bus_op_o    (own_op),
        .bus_addr_o  (bus_addr_o),
        .wr_en_o     (wa_en),
        .wr_st_o     (wa_st),
        .wr_tag_o    (wa_tag)
    );

    mesi_snoop_resp snoop_i (
        .snp_act  (snp_act),
        .snp_op   (snp_op),
        .tag_eq   (b_tag == snp_tag),
        .line_st  (b_st),
        .shared_o (shared_o),
        .wb_o     (snp_wb_o),
        .upd_en   (wb_en),
        .upd_st   (wb_st)
    );

    // R8
    snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_act && snp_hit && (snp_op == OP_RDX || snp_op == OP_INV)) |=>
            ((snp_addr_i != $past(snp_addr_i)) || b_st == ST_I));
    // R7
    snoop_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_act && snp_hit && snp_op == OP_RD) |=>
            ((snp_addr_i != $past(snp_addr_i)) || b_st == ST_S));
    // R9
    own_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (!shared_o && !snp_wb_o));
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
// Two controllers on one bus with a bench arbiter and wired shared line.
module mesi_snoop_ctrl_tb_top;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          c_valid [2];
    logic          c_write [2];
    logic [AW-1:0] c_addr  [2];
    logic          c_done  [2];
    logic [1:0]    c_state [2];
    logic          b_req   [2];
    logic          b_gnt   [2];
    logic          b_val   [2];
    logic [1:0]    b_cmd   [2];
    logic [AW-1:0] b_addr  [2];
    logic          sh      [2];
    logic          wbp     [2];
    logic          prio1 = 1'b0;

    logic          bus_v;
    logic [1:0]    bus_c;
    logic [AW-1:0] bus_a;

    // Arbiter and shared bus.
    assign b_gnt[1] = b_req[1] && (prio1 || !b_req[0]);
    assign b_gnt[0] = b_req[0] && !b_gnt[1];
    assign bus_v = b_val[0] | b_val[1];
    assign bus_c = b_val[1] ? b_cmd[1] : b_cmd[0];
    assign bus_a = b_val[1] ? b_addr[1] : b_addr[0];

    mesi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid_i(c_valid[0]), .cpu_write_i(c_write[0]), .cpu_addr_i(c_addr[0]),
        .cpu_done_o(c_done[0]), .cpu_state_o(c_state[0]),
        .bus_req_o(b_req[0]), .bus_gnt_i(b_gnt[0]), .bus_valid_o(b_val[0]),
        .bus_cmd_o(b_cmd[0]), .bus_addr_o(b_addr[0]),
        .snp_valid_i(bus_v), .snp_cmd_i(bus_c), .snp_addr_i(bus_a),
        .shared_i(sh[1]), .shared_o(sh[0]), .snp_wb_o(wbp[0]));

    mesi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(2)) peer_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid_i(c_valid[1]), .cpu_write_i(c_write[1]), .cpu_addr_i(c_addr[1]),
        .cpu_done_o(c_done[1]), .cpu_state_o(c_state[1]),
        .bus_req_o(b_req[1]), .bus_gnt_i(b_gnt[1]), .bus_valid_o(b_val[1]),
        .bus_cmd_o(b_cmd[1]), .bus_addr_o(b_addr[1]),
        .snp_valid_i(bus_v), .snp_cmd_i(bus_c), .snp_addr_i(bus_a),
        .shared_i(sh[0]), .shared_o(sh[1]), .snp_wb_o(wbp[1]));

    int errors = 0;
    int checks = 0;
    int n_bus [2];
    int n_flush;
    int first_cmd [2];

    // Bus monitor, sampled mid-cycle.
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (b_val[k]) begin
                if (n_bus[k] == 0) first_cmd[k] = int'(b_cmd[k]);
                n_bus[k]++;
            end
            if (wbp[k]) n_flush++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_bus[0] = 0; n_bus[1] = 0; n_flush = 0;
        first_cmd[0] = -1; first_cmd[1] = -1;
    endtask

    // Hold requester k until done, release after the committing edge.
    task automatic wait_done(input int k);
        logic got;
        got = 1'b0;
        while (!got) begin
            got = c_done[k];
            @(posedge clk); #1;
            if (got) c_valid[k] = 1'b0;
            else begin @(negedge clk); #1; end
        end
    endtask

    task automatic do_op(input int k, input logic wr, input logic [AW-1:0] a);
        @(negedge clk);
        c_valid[k] = 1'b1; c_write[k] = wr; c_addr[k] = a;
        #1;
        wait_done(k);
    endtask

    function automatic int st_of(input int k, input logic [AW-1:0] a);
        return 0;
    endfunction

    task automatic query(input logic [AW-1:0] a, output int s0, output int s1);
        c_addr[0] = a; c_addr[1] = a;
        #1;
        s0 = int'(c_state[0]); s1 = int'(c_state[1]);
    endtask

    // Vector: who, write, addr, exp requester state, exp other state,
    // exp bus commands by requester, first command, exp intervention count.
    localparam logic [16:0] VEC [12] = '{
        {1'b0, 1'b0, 6'h05, 2'd2, 2'd0, 2'd1, 2'd0, 1'b0},
        {1'b0, 1'b1, 6'h05, 2'd3, 2'd0, 2'd0, 2'd0, 1'b0},
        {1'b1, 1'b0, 6'h05, 2'd1, 2'd1, 2'd1, 2'd0, 1'b1},
        {1'b1, 1'b1, 6'h05, 2'd3, 2'd0, 2'd1, 2'd2, 1'b0},
        {1'b0, 1'b1, 6'h05, 2'd3, 2'd0, 2'd1, 2'd1, 1'b1},
        {1'b0, 1'b0, 6'h15, 2'd2, 2'd0, 2'd2, 2'd3, 1'b0},
        {1'b1, 1'b0, 6'h15, 2'd1, 2'd1, 2'd1, 2'd0, 1'b0},
        {1'b0, 1'b0, 6'h15, 2'd1, 2'd1, 2'd0, 2'd0, 1'b0},
        {1'b1, 1'b1, 6'h06, 2'd3, 2'd0, 2'd1, 2'd1, 1'b0},
        {1'b0, 1'b0, 6'h06, 2'd1, 2'd1, 2'd1, 2'd0, 1'b1},
        {1'b0, 1'b1, 6'h06, 2'd3, 2'd0, 2'd1, 2'd2, 1'b0},
        {1'b1, 1'b0, 6'h05, 2'd2, 2'd0, 2'd1, 2'd0, 1'b0}
    };

    function automatic string req_of(input int i);
        case (i)
            0: return "R2";   1: return "R4";   2: return "R7";   3: return "R5";
            4: return "R8";   5: return "R3";   6: return "R6";   7: return "R4";
            8: return "R5";   9: return "R7";   10: return "R5";  default: return "R9";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0, s1;
        logic d0;
        for (int k = 0; k < 2; k++) begin
            c_valid[k] = 1'b0; c_write[k] = 1'b0; c_addr[k] = '0;
        end
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        query(6'h05, s0, s1);
        chk("R1", "reset state p0", s0, 0);
        chk("R1", "reset state p1", s1, 0);
        query(6'h3E, s0, s1);
        chk("R1", "reset state p0 hi", s0, 0);
        chk("R1", "idle bus_req", int'(b_req[0] | b_req[1]), 0);
        chk("R1", "idle done", int'(c_done[0] | c_done[1]), 0);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            int who, oth;
            logic [16:0] v;
            v = VEC[i];
            who = int'(v[16]);
            oth = 1 - who;
            clear_mon();
            do_op(who, v[15], v[14:9]);
            query(v[14:9], s0, s1);
            chk(req_of(i), $sformatf("op%0d requester state", i), who ? s1 : s0, int'(v[8:7]));
            chk(req_of(i), $sformatf("op%0d other state", i), who ? s0 : s1, int'(v[6:5]));
            chk(req_of(i), $sformatf("op%0d bus commands", i), n_bus[who], int'(v[4:3]));
            if (v[4:3] != 2'd0)
                chk(req_of(i), $sformatf("op%0d first command", i), first_cmd[who], int'(v[2:1]));
            chk(req_of(i), $sformatf("op%0d interventions", i), n_flush, int'(v[0]));
            chk(req_of(i), $sformatf("op%0d other silent", i), n_bus[oth], 0);
        end

        // R9: other tag on same index kept its line through op 11's snoop
        query(6'h15, s0, s1);
        chk("R9", "p0 other-tag line kept", s0, 1);

        // R10: both upgrade a Shared line, peer wins the bus first
        do_op(0, 1'b0, 6'h07);
        do_op(1, 1'b0, 6'h07);
        query(6'h07, s0, s1);
        chk("R10", "setup both shared", s0 * 4 + s1, 1 * 4 + 1);
        clear_mon();
        prio1 = 1'b1;
        @(negedge clk);
        c_valid[0] = 1'b1; c_write[0] = 1'b1; c_addr[0] = 6'h07;
        c_valid[1] = 1'b1; c_write[1] = 1'b1; c_addr[1] = 6'h07;
        #1;
        while (c_valid[0] || c_valid[1]) begin
            logic g0, g1;
            g0 = c_valid[0] && c_done[0];
            g1 = c_valid[1] && c_done[1];
            @(posedge clk); #1;
            if (g0) c_valid[0] = 1'b0;
            if (g1) c_valid[1] = 1'b0;
            @(negedge clk); #1;
        end
        prio1 = 1'b0;
        chk("R10", "peer upgrade command", first_cmd[1], 2);
        chk("R10", "loser reissues as ownership read", first_cmd[0], 1);
        query(6'h07, s0, s1);
        chk("R10", "loser ends Modified", s0, 3);
        chk("R10", "winner invalidated", s1, 0);

        // R11: local store hit collides with a snooped read on the same index
        do_op(0, 1'b0, 6'h0B);
        query(6'h0B, s0, s1);
        chk("R11", "setup exclusive", s0, 2);
        clear_mon();
        @(negedge clk);
        c_valid[1] = 1'b1; c_write[1] = 1'b0; c_addr[1] = 6'h0B;
        #1;
        while (!b_val[1]) begin @(negedge clk); #1; end
        c_valid[0] = 1'b1; c_write[0] = 1'b1; c_addr[0] = 6'h0B;
        #1;
        d0 = c_done[0];
        chk("R11", "local hit held during snoop", int'(d0), 0);
        chk("R6", "shared answer from exclusive", int'(sh[0]), 1);
        chk("R6", "no intervention from clean", int'(wbp[0]), 0);
        @(posedge clk); #1;
        c_valid[1] = 1'b0;
        @(negedge clk); #1;
        wait_done(0);
        chk("R11", "re-evaluated as upgrade", first_cmd[0], 2);
        query(6'h0B, s0, s1);
        chk("R11", "store lands Modified", s0, 3);
        chk("R11", "peer invalidated", s1, 0);

        // R1: reset from a busy state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        query(6'h0B, s0, s1);
        chk("R1", "post-reset p0", s0, 0);
        query(6'h06, s0, s1);
        chk("R1", "post-reset p0 idx2", s0, 0);
        query(6'h05, s0, s1);
        chk("R1", "post-reset p1", s1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule